// File: doc/BRIEF.md
# Lockstep Multi-Converter Acquisition Sequencer

This block paces three 24-bit, four-channel delta-sigma converters so that all twelve analog channels are captured at the same instant. One frame timer runs without stopping and sets the rhythm for two overlapped cycles. The send cycle shifts the command word to every converter on a single shared line and then issues a common start pulse. The receive cycle runs alongside it on the same serial clock. It reads the results of the previous conversion from every converter at once, through one serial data input per converter. It then presents the twelve words one per cycle, each with a valid strobe and its channel and converter indices.

The frame length in clock cycles comes from a 16-bit count loaded with each configuration write. The same write also loads the command word and restarts the frame from its first cycle. Any count too short to fit a full frame is raised to the shortest frame that still holds one.

Top module: `acq_sequencer`

## Requirements
- R1: A frame lasts max(count, 207) clock cycles. Frames follow one another without gaps, with the frame timer at cycle 0 right after reset.
- R2: Serial bits start at frame cycle 2, and each bit lasts two clock cycles: `adcSclk` is low in the first and high in the second. The 8-bit command word goes out MSB first on `adcCmd` during the first 8 bit periods, and `adcCmd` is 0 at all other times.
- R3: `adcStart` is high for exactly one cycle, at frame cycle 18, which is right after the last command bit. `adcSclk` is low in that cycle.
- R4: All converters are shifted on the same clock edges. Each `adcDin` bit is taken at the clock edge that ends an `adcSclk`-high cycle, and the input has no effect at any other time. 96 bits are taken per frame, channel 0 first and each word MSB first.
- R5: After the last data bit, frame cycles 194 to 205 each emit one word with `wordValid` high. The order is channel-major (channel 0 from converters 0, 1 and 2, then channel 1, and so on). `wordCh` and `wordAdc` give the indices as binary numbers.
- R6: The first frame after reset or after a configuration write emits no words.
- R7: A configuration write loads the command word and the count and restarts the frame at cycle 0 on the next cycle. A word sequence that is under way stops at once.
- R8: Count values below 207, including 0, give a 207-cycle frame.
- R9: While in reset and right after it, all outputs are 0.
- R10: The command and start of frame n go out on the same serial clock as the receive of frame n−1's conversion, so both cycles overlap inside one frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfgWrite | input | 1 | Load the command word and count, and restart the frame |
| cfgWord | input | 8 | Command word sent to every converter |
| cfgCount | input | 16 | Frame length in clock cycles |
| adcDin | input | 3 | Serial data, one bit per converter |
| adcSclk | output | 1 | Shared serial clock |
| adcCmd | output | 1 | Shared serial command line |
| adcStart | output | 1 | Common conversion start pulse |
| wordValid | output | 1 | Store strobe for a completed word |
| wordData | output | 24 | Completed sample word |
| wordCh | output | 2 | Channel index of the word |
| wordAdc | output | 2 | Converter index of the word |

## Verification
The hardest case to reach from the ports is a configuration write that lands in the middle of the word sequence of a primed frame, together with the clamp boundary (counts of 5, 207 and 208). The bench follows the frame position in its own model and waits until that model is at a chosen cycle (inside the store window, or in the middle of the receive) before it issues the write. Between the sampling edges it drives the inverse of each data bit onto `adcDin`, so any capture on the wrong edge shows up in the words.

// File: rtl/acq_pkg.sv
package acq_pkg;
  localparam int unsigned DEF_NUM_ADC   = 3;
  localparam int unsigned DEF_NUM_CH    = 4;
  localparam int unsigned DEF_SAMPLE_W  = 24;
  localparam int unsigned DEF_CMD_W     = 8;
  localparam int unsigned DEF_CNT_W     = 16;
  localparam int unsigned DEF_SETUP_CYC = 2;

  typedef enum logic [1:0] {SND_SETUP, SND_SHIFT, SND_SAMPLE, SND_CONVERT} snd_phase_e;
  typedef enum logic [1:0] {RCV_SETUP, RCV_SHIFT, RCV_STORE, RCV_IDLE} rcv_phase_e;

  typedef struct packed {
    logic frameStart;
    logic cmdActive;
    logic cmdAdvance;
    logic capture;
    logic store;
  } acq_strobe_t;
endpackage

// File: rtl/acq_seq_ctrl.sv
module acq_seq_ctrl
  import acq_pkg::*;
#(
  parameter int unsigned NUM_ADC   = DEF_NUM_ADC,
  parameter int unsigned NUM_CH    = DEF_NUM_CH,
  parameter int unsigned SAMPLE_W  = DEF_SAMPLE_W,
  parameter int unsigned CMD_W     = DEF_CMD_W,
  parameter int unsigned CNT_W     = DEF_CNT_W,
  parameter int unsigned SETUP_CYC = DEF_SETUP_CYC,
  parameter int unsigned CH_IW     = 2,
  parameter int unsigned ADC_IW    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgWrite,
  input  logic [CNT_W-1:0]  cfgCount,
  output acq_strobe_t       strobes,
  output logic              sclk,
  output logic              startPulse,
  output logic [CH_IW-1:0]  storeCh,
  output logic [ADC_IW-1:0] storeAdc
);
  localparam int unsigned RX_BITS    = NUM_CH * SAMPLE_W;
  localparam int unsigned BIT_BEGIN  = SETUP_CYC;
  localparam int unsigned CMD_END    = SETUP_CYC + 2 * CMD_W;
  localparam int unsigned BIT_END    = SETUP_CYC + 2 * RX_BITS;
  localparam int unsigned STORE_END  = BIT_END + NUM_ADC * NUM_CH;
  localparam int unsigned MIN_PERIOD = STORE_END + 1;

  localparam logic [CNT_W-1:0] BIT_BEGIN_C = CNT_W'(BIT_BEGIN);
  localparam logic [CNT_W-1:0] CMD_END_C   = CNT_W'(CMD_END);
  localparam logic [CNT_W-1:0] BIT_END_C   = CNT_W'(BIT_END);
  localparam logic [CNT_W-1:0] STORE_END_C = CNT_W'(STORE_END);
  localparam logic [CNT_W-1:0] MIN_P_C     = CNT_W'(MIN_PERIOD);
  localparam logic [ADC_IW-1:0] LAST_ADC   = ADC_IW'(NUM_ADC - 1);

  logic [CNT_W-1:0] countReg;
  logic [CNT_W-1:0] timer;
  logic [CNT_W-1:0] period;
  logic             primed;
  logic             frameEnd;
  logic             halfHigh;
  snd_phase_e       sendPhase;
  rcv_phase_e       recvPhase;

  // frame length with the floor applied
  assign period   = (countReg < MIN_P_C) ? MIN_P_C : countReg;
  assign frameEnd = (timer == period - 1'b1);
  // second cycle of every bit period
  assign halfHigh = (timer[0] != BIT_BEGIN_C[0]);

  always_comb begin
    if (timer < BIT_BEGIN_C)     sendPhase = SND_SETUP;
    else if (timer < CMD_END_C)  sendPhase = SND_SHIFT;
    else if (timer == CMD_END_C) sendPhase = SND_SAMPLE;
    else                         sendPhase = SND_CONVERT;
  end

  always_comb begin
    if (timer < BIT_BEGIN_C)       recvPhase = RCV_SETUP;
    else if (timer < BIT_END_C)    recvPhase = RCV_SHIFT;
    else if (timer < STORE_END_C)  recvPhase = RCV_STORE;
    else                           recvPhase = RCV_IDLE;
  end

  always_comb begin
    strobes.frameStart = (timer == '0);
    strobes.cmdActive  = (sendPhase == SND_SHIFT);
    strobes.cmdAdvance = (sendPhase == SND_SHIFT) && halfHigh;
    strobes.capture    = (recvPhase == RCV_SHIFT) && halfHigh;
    strobes.store      = (recvPhase == RCV_STORE) && primed;
  end

  assign sclk       = (recvPhase == RCV_SHIFT) && halfHigh;
  assign startPulse = (sendPhase == SND_SAMPLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      countReg <= '0;
      timer    <= '0;
      primed   <= 1'b0;
      storeCh  <= '0;
      storeAdc <= '0;
    end else if (cfgWrite) begin
      countReg <= cfgCount;
      timer    <= '0;
      primed   <= 1'b0;
      storeCh  <= '0;
      storeAdc <= '0;
    end else if (frameEnd) begin
      timer    <= '0;
      primed   <= 1'b1;
      storeCh  <= '0;
      storeAdc <= '0;
    end else begin
      timer <= timer + 1'b1;
      if (recvPhase == RCV_STORE) begin
        if (storeAdc == LAST_ADC) begin
          storeAdc <= '0;
          storeCh  <= storeCh + 1'b1;
        end else begin
          storeAdc <= storeAdc + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/acq_seq_datapath.sv
module acq_seq_datapath
  import acq_pkg::*;
#(
  parameter int unsigned NUM_ADC  = DEF_NUM_ADC,
  parameter int unsigned NUM_CH   = DEF_NUM_CH,
  parameter int unsigned SAMPLE_W = DEF_SAMPLE_W,
  parameter int unsigned CMD_W    = DEF_CMD_W,
  parameter int unsigned CH_IW    = 2,
  parameter int unsigned ADC_IW   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfgWrite,
  input  logic [CMD_W-1:0]    cfgWord,
  input  acq_strobe_t         strobes,
  input  logic [CH_IW-1:0]    storeCh,
  input  logic [ADC_IW-1:0]   storeAdc,
  input  logic [NUM_ADC-1:0]  adcDin,
  output logic                adcCmd,
  output logic                wordValid,
  output logic [SAMPLE_W-1:0] wordData,
  output logic [CH_IW-1:0]    wordCh,
  output logic [ADC_IW-1:0]   wordAdc
);
  localparam int unsigned RX_BITS = NUM_CH * SAMPLE_W;

  logic [CMD_W-1:0]    cmdReg;
  logic [CMD_W-1:0]    cmdSh;
  logic [SAMPLE_W-1:0] chWords [NUM_ADC][NUM_CH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmdReg <= '0;
      cmdSh  <= '0;
    end else begin
      if (cfgWrite) cmdReg <= cfgWord;
      if (strobes.frameStart)      cmdSh <= cmdReg;
      else if (strobes.cmdAdvance) cmdSh <= {cmdSh[CMD_W-2:0], 1'b0};
    end
  end

  assign adcCmd = strobes.cmdActive & cmdSh[CMD_W-1];

  // one receive shifter per converter, all on the same capture strobe
  for (genvar g = 0; g < NUM_ADC; g++) begin : g_lane
    logic [RX_BITS-1:0] rxSh;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               rxSh <= '0;
      else if (strobes.capture) rxSh <= {rxSh[RX_BITS-2:0], adcDin[g]};
    end
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign chWords[g][c] = rxSh[RX_BITS-1-c*SAMPLE_W -: SAMPLE_W];
    end
  end

  assign wordValid = strobes.store;
  assign wordCh    = strobes.store ? storeCh  : '0;
  assign wordAdc   = strobes.store ? storeAdc : '0;
  assign wordData  = strobes.store ? chWords[storeAdc][storeCh] : '0;
endmodule

// File: rtl/acq_sequencer.sv
module acq_sequencer
  import acq_pkg::*;
#(
  parameter int unsigned NUM_ADC   = DEF_NUM_ADC,
  parameter int unsigned NUM_CH    = DEF_NUM_CH,
  parameter int unsigned SAMPLE_W  = DEF_SAMPLE_W,
  parameter int unsigned CMD_W     = DEF_CMD_W,
  parameter int unsigned CNT_W     = DEF_CNT_W,
  parameter int unsigned SETUP_CYC = DEF_SETUP_CYC,
  localparam int unsigned CH_IW    = (NUM_CH  > 1) ? $clog2(NUM_CH)  : 1,
  localparam int unsigned ADC_IW   = (NUM_ADC > 1) ? $clog2(NUM_ADC) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfgWrite,
  input  logic [CMD_W-1:0]    cfgWord,
  input  logic [CNT_W-1:0]    cfgCount,
  input  logic [NUM_ADC-1:0]  adcDin,
  output logic                adcSclk,
  output logic                adcCmd,
  output logic                adcStart,
  output logic                wordValid,
  output logic [SAMPLE_W-1:0] wordData,
  output logic [CH_IW-1:0]    wordCh,
  output logic [ADC_IW-1:0]   wordAdc
);
  acq_strobe_t       strobes;
  logic [CH_IW-1:0]  storeCh;
  logic [ADC_IW-1:0] storeAdc;

  acq_seq_ctrl #(
    .NUM_ADC(NUM_ADC), .NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .CMD_W(CMD_W),
    .CNT_W(CNT_W), .SETUP_CYC(SETUP_CYC), .CH_IW(CH_IW), .ADC_IW(ADC_IW)
  ) i_ctrl (
    .clk(clk), .rst_n(rst_n), .cfgWrite(cfgWrite), .cfgCount(cfgCount),
    .strobes(strobes), .sclk(adcSclk), .startPulse(adcStart),
    .storeCh(storeCh), .storeAdc(storeAdc)
  );

  acq_seq_datapath #(
    .NUM_ADC(NUM_ADC), .NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .CMD_W(CMD_W),
    .CH_IW(CH_IW), .ADC_IW(ADC_IW)
  ) i_dp (
    .clk(clk), .rst_n(rst_n), .cfgWrite(cfgWrite), .cfgWord(cfgWord),
    .strobes(strobes), .storeCh(storeCh), .storeAdc(storeAdc), .adcDin(adcDin),
    .adcCmd(adcCmd), .wordValid(wordValid), .wordData(wordData),
    .wordCh(wordCh), .wordAdc(wordAdc)
  );
endmodule

// File: rtl/acq_sequencer_chk.sv
module acq_sequencer_chk #(
  parameter int unsigned NUM_ADC = 3,
  parameter int unsigned CH_IW   = 2,
  parameter int unsigned ADC_IW  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfgWrite,
  input logic              adcSclk,
  input logic              adcCmd,
  input logic              adcStart,
  input logic              wordValid,
  input logic [CH_IW-1:0]  wordCh,
  input logic [ADC_IW-1:0] wordAdc
);
  localparam logic [ADC_IW-1:0] LAST_ADC = ADC_IW'(NUM_ADC - 1);

  AST_SCLK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adcSclk) |=> !adcSclk); // R2
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    adcStart |=> !adcStart); // R3
  AST_START_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    adcStart |-> (!adcSclk && !adcCmd)); // R3
  AST_STORE_AFTER_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    wordValid |-> (!adcSclk && !adcCmd)); // R5
  AST_ADC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wordValid |-> (wordAdc <= LAST_ADC)); // R5
  AST_ADC_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (wordValid && $past(wordValid)) |->
      (wordAdc == (($past(wordAdc) == LAST_ADC) ? '0 : ADC_IW'($past(wordAdc) + 1'b1)))); // R5
  AST_CH_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (wordValid && $past(wordValid) && $past(wordAdc) == LAST_ADC) |->
      (wordCh == CH_IW'($past(wordCh) + 1'b1))); // R5
  AST_CFG_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    cfgWrite |=> (!wordValid && !adcSclk && !adcStart && !adcCmd)); // R7
endmodule

bind acq_sequencer acq_sequencer_chk #(
  .NUM_ADC(NUM_ADC), .CH_IW(CH_IW), .ADC_IW(ADC_IW)
) i_chk (
  .clk(clk), .rst_n(rst_n), .cfgWrite(cfgWrite), .adcSclk(adcSclk),
  .adcCmd(adcCmd), .adcStart(adcStart), .wordValid(wordValid),
  .wordCh(wordCh), .wordAdc(wordAdc)
);

// File: tb/test_acq_sequencer.sv
`timescale 1ns/1ps
module test_acq_sequencer;
  localparam int MINP = 207;
  localparam int BB   = 2;    // first serial cycle
  localparam int CE   = 18;   // start pulse cycle
  localparam int BE   = 194;  // first store cycle
  localparam int SE   = 206;  // end of store window

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfgWrite = 1'b0;
  logic [7:0]  cfgWord = '0;
  logic [15:0] cfgCount = '0;
  logic [2:0]  adcDin = '0;
  logic        adcSclk, adcCmd, adcStart, wordValid;
  logic [23:0] wordData;
  logic [1:0]  wordCh, wordAdc;

  int checks = 0;
  int errors = 0;
  int stores = 0;
  bit done = 0;

  // behavioural model state
  int mt = 0;
  int mp = MINP;
  int frameId = 0;
  bit mpr = 0;
  logic [7:0] mcmd = '0;

  always #10 clk = ~clk;

  acq_sequencer i_acq_sequencer (
    .clk(clk), .rst_n(rst_n), .cfgWrite(cfgWrite), .cfgWord(cfgWord),
    .cfgCount(cfgCount), .adcDin(adcDin), .adcSclk(adcSclk), .adcCmd(adcCmd),
    .adcStart(adcStart), .wordValid(wordValid), .wordData(wordData),
    .wordCh(wordCh), .wordAdc(wordAdc)
  );

  function automatic logic [23:0] sampleVal(int f, int a, int c);
    if (f % 5 == 3) return (a % 2 == 0) ? 24'hFFFFFF : 24'h800001;
    return 24'(f * 32'h3A5C1 + a * 32'h1F07 + c * 32'h9B3 + 32'h5A5A5A);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      if (errors <= 30) $display("FAIL %s actual=%0h expected=%0h (cycle %0d of frame)", tag, act, exp, mt);
    end
  endtask

  // one cycle: compare at the falling edge, apply inputs, advance the model
  task automatic tick(input bit rstn, input bit wr, input logic [7:0] cmd, input logic [15:0] cnt);
    bit eSclk, eCmd, eStart, eValid;
    int eCh, eAdc;
    @(negedge clk);
    eSclk  = (mt >= BB && mt < BE && ((mt - BB) % 2 == 1));
    eCmd   = (mt >= BB && mt < CE) ? mcmd[7 - (mt - BB) / 2] : 1'b0;
    eStart = (mt == CE);
    eValid = mpr && mt >= BE && mt < SE;
    chk(adcSclk == eSclk, "R2 R4 sclk", 32'(adcSclk), 32'(eSclk));
    chk(adcCmd == eCmd, "R2 R10 cmd", 32'(adcCmd), 32'(eCmd));
    chk(adcStart == eStart, "R1 R3 start", 32'(adcStart), 32'(eStart));
    chk(wordValid == eValid, "R5 R6 R7 valid", 32'(wordValid), 32'(eValid));
    if (eValid) begin
      eCh  = (mt - BE) / 3;
      eAdc = (mt - BE) % 3;
      stores++;
      chk(wordCh == 2'(eCh), "R5 ch", 32'(wordCh), 32'(eCh));
      chk(wordAdc == 2'(eAdc), "R5 adc", 32'(wordAdc), 32'(eAdc));
      chk(wordData == sampleVal(frameId, eAdc, eCh), "R4 R10 data", 32'(wordData),
          32'(sampleVal(frameId, eAdc, eCh)));
    end
    // inputs for the coming edge; inverse data while sclk is low (R4)
    for (int a = 0; a < 3; a++) begin
      if (mt >= BB && mt < BE) begin
        int rel = mt - BB;
        int bi  = rel / 2;
        logic v = sampleVal(frameId, a, bi / 24)[23 - (bi % 24)];
        adcDin[a] = (rel % 2 == 1) ? v : ~v;
      end else begin
        adcDin[a] = 1'((mt + a) % 2);
      end
    end
    rst_n    = rstn;
    cfgWrite = wr;
    cfgWord  = cmd;
    cfgCount = cnt;
    if (!rstn) begin
      mt = 0; mpr = 0; mcmd = '0; mp = MINP; frameId++;
    end else if (wr) begin
      mt = 0; mpr = 0; mcmd = cmd; mp = (int'(cnt) < MINP) ? MINP : int'(cnt); frameId++;
    end else if (mt == mp - 1) begin
      mt = 0; mpr = 1; frameId++;
    end else begin
      mt++;
    end
  endtask

  task automatic run(input int n);
    repeat (n) tick(1'b1, 1'b0, 8'h00, 16'h0000);
  endtask

  task automatic runUntil(input int target);
    int guard = 0;
    while (mt != target && guard < 5000) begin
      tick(1'b1, 1'b0, 8'h00, 16'h0000);
      guard++;
    end
  endtask

  task automatic cfg(input logic [7:0] cmd, input logic [15:0] cnt);
    tick(1'b1, 1'b1, cmd, cnt);
  endtask

  initial begin
    repeat (4) tick(1'b0, 1'b0, 8'h00, 16'h0000);
    tick(1'b1, 1'b0, 8'h00, 16'h0000);
    // R9: outputs are zero just after release
    chk({adcSclk, adcCmd, adcStart, wordValid} == 4'b0, "R9 reset outputs",
        32'({adcSclk, adcCmd, adcStart, wordValid}), 32'h0);
    run(450);                 // R1 R6 default frame, first frame silent
    cfg(8'hA5, 16'd300);      // R7 new word and count
    run(700);
    cfg(8'h3C, 16'd5);        // R8 clamp of a short count
    run(500);
    cfg(8'h81, 16'd207);      // R8 exactly at the floor
    run(450);
    cfg(8'hC3, 16'd208);      // R1 one above the floor
    run(450);
    runUntil(197);            // R7 abort inside the store window
    cfg(8'h5A, 16'd250);
    run(600);
    runUntil(60);             // R7 write during receive, count 0 clamps (R8)
    cfg(8'hFF, 16'd0);
    run(700);
    repeat (3) tick(1'b0, 1'b0, 8'h00, 16'h0000);   // R9 reset mid-run
    tick(1'b1, 1'b0, 8'h00, 16'h0000);
    chk({adcSclk, adcCmd, adcStart, wordValid} == 4'b0, "R9 reset outputs mid-run",
        32'({adcSclk, adcCmd, adcStart, wordValid}), 32'h0);
    run(450);
    chk(stores > 100, "R5 words were stored", 32'(stores), 32'd101);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule